// File: doc/BRIEF.md
# I2C Target Byte Shifter with Own-Address Compare

This block is the serial front end of an I2C target inside a small peripheral. One 8-bit data register serves both as the CPU-visible data holder and as the shift register on the bus. A second 8-bit register holds the own 7-bit address in its upper bits and a format bit in bit 0. The block watches the already synchronized SCL and SDA lines, detects START and STOP, collects the first byte after each START and compares it with the programmed address. It acknowledges by asserting an open-drain pull enable on SDA.

Data moves under CPU control. A CPU write to the data register loads a byte and arms it for transmission. A CPU read returns the last byte and arms the reception of the next one. A data byte that nobody armed is neither acknowledged nor driven. The CPU may touch the data register only between bytes. The address register can be changed only while the block is disabled.

Top module: `i2c_tgt_shifter`

## Requirements
- R1: After reset the address register reads 0x00, `sda_pull` is 0, and `busy`, `addressed` and `byte_done` are 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including in the middle of a byte, abandons that byte and re-arms the address compare. A STOP clears `addressed`.
- R3: With format bit 0 = 0, the first byte after a START is shifted in MSB first. If its bits 7..1 equal address-register bits 7..1 (bit 0 of the byte is not compared), the block asserts `sda_pull` through the ninth SCL clock and sets `addressed`.
- R4: If the address does not match, no acknowledge is given, SDA stays released, and later bytes get no acknowledge and no `byte_done` until the next START.
- R5: When address-byte bit 0 = 1 (`tx_mode` = 1), the block transmits the armed data-register byte MSB first. It changes SDA only while SCL is low and releases SDA during the ninth clock.
- R6: When address-byte bit 0 = 0, each armed data byte is shifted in MSB first on SCL rising edges and acknowledged in the ninth clock. A CPU read at `cpu_addr` = 0 returns the byte, and that read arms the next one. After the address ACK, the data register holds the address byte.
- R7: A data byte that was not armed (no CPU write for transmit, no CPU read for receive since the previous byte) is not acknowledged, is not driven, produces no `byte_done`, and leaves the data register unchanged.
- R8: `busy` is 1 from the first SCL rising edge of an accepted byte up to the falling edge that ends its ninth clock. In the cycle after that edge, `byte_done` pulses for exactly one cycle while `busy` is 0.
- R9: A CPU access to the data register while a byte is shifting produces a one-cycle `acc_err` pulse in the next cycle. A write made then is discarded.
- R10: The address register (`cpu_addr` = 1) accepts writes and returns its value only while `blk_en` = 0. While `blk_en` = 1, writes are ignored and reads return 0.
- R11: With format bit 0 = 1, no address compare takes place. The first byte after a START is received as data and acknowledged, and `tx_mode` stays 0.
- R12: During transmit, a released SDA (NACK) sampled in the ninth clock ends the transfer: the block releases SDA and drives nothing more until the next START.
- R13: While `blk_en` = 0, the bus is ignored: `sda_pull`, `busy` and `addressed` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Block enable; also unlocks the address register when 0 |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| sda_pull | output | 1 | Open-drain enable, 1 pulls SDA low |
| cpu_sel | input | 1 | CPU access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = data register, 1 = address register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| busy | output | 1 | Byte shift in progress |
| byte_done | output | 1 | One-cycle pulse after each accepted byte |
| acc_err | output | 1 | Pulse: data register touched while busy |
| addressed | output | 1 | Block is the selected target |
| tx_mode | output | 1 | Direction latched from address bit 0 |

## Verification
The bench sweeps all 128 own addresses. For each one it sends a matching address with either direction bit and a mismatch that differs in one rotating bit. A compare that includes bit 0 or drops a bit would lose an ACK or give a false one. After each mismatch a second byte equal to the own address is sent: a design that resumes comparing before a START would acknowledge it. The receive and transmit runs use all-zero, all-one, alternating and single-bit patterns, which catch LSB-first order and shifts that are off by one. Unarmed bytes, a write in the middle of a byte, a restart in the middle of a byte and a master NACK each target an edge a design could mishandle: stray ACKs, corrupted data, stale compares, or driving SDA after the transfer has ended.

// File: rtl/i2cts_pkg.sv
package i2cts_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;
endpackage

// File: rtl/i2cts_bus_edge.sv
module i2cts_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_in;
    sda_d = sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign start_det = scl_in & scl_q & sda_q & ~sda_in;
  assign stop_det  = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/i2cts_regs.sv
module i2cts_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_en,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic          cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          shift_busy,
  input  logic          shift_in,
  input  logic          shift_out,
  input  logic          sda_now,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] own_q,
  output logic [DW-1:0] cpu_rdata,
  output logic          arm_req,
  output logic          acc_err
);
  logic [DW-1:0] dat_d, own_d;
  logic          err_d, err_q;
  logic          dat_acc, own_acc;

  assign dat_acc = cpu_sel & ~cpu_addr;
  assign own_acc = cpu_sel & cpu_addr;
  assign arm_req = dat_acc & ~shift_busy;

  always_comb begin
    dat_d = dat_q;
    if (shift_in)
      dat_d = {dat_q[DW-2:0], sda_now};
    else if (shift_out)
      dat_d = {dat_q[DW-2:0], 1'b0};
    else if (dat_acc && cpu_wr && !shift_busy)
      dat_d = cpu_wdata;
  end

  always_comb begin
    own_d = own_q;
    if (own_acc && cpu_wr && !blk_en)
      own_d = cpu_wdata;
  end

  always_comb begin
    err_d = dat_acc & shift_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      own_q <= '0;
      err_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      own_q <= own_d;
      err_q <= err_d;
    end
  end

  assign acc_err   = err_q;
  assign cpu_rdata = cpu_addr ? (blk_en ? '0 : own_q) : dat_q;
endmodule

// File: rtl/i2cts_seq.sv
module i2cts_seq
  import i2cts_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_en,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_now,
  input  logic          arm_req,
  input  logic [DW-1:0] dat_q,
  input  logic [DW-1:0] own_q,
  output logic          shift_in,
  output logic          shift_out,
  output logic          shift_busy,
  output logic          busy,
  output logic          byte_done,
  output logic          addressed,
  output logic          tx_mode,
  output logic          sda_pull
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  logic          tx_q, tx_d;
  logic          arm_q, arm_d;
  logic          take_q, take_d;
  logic          busy_q, busy_d;
  logic          hit_q, hit_d;
  logic          nack_q, nack_d;
  logic          done_q, done_d;
  logic          fmt_free, addr_eq, in_xfer;

  assign fmt_free = own_q[0];
  assign addr_eq  = (dat_q[DW-1:1] == own_q[DW-1:1]);
  assign in_xfer  = (ph_q == PH_ADDR) || (ph_q == PH_DATA);

  always_comb begin
    ph_d = ph_q;  cnt_d = cnt_q;  ack_d = ack_q;  tx_d = tx_q;
    arm_d = arm_q;  take_d = take_q;  busy_d = busy_q;  hit_d = hit_q;
    nack_d = nack_q;  done_d = 1'b0;  shift_in = 1'b0;  shift_out = 1'b0;
    if (!blk_en || start_det || stop_det) begin
      ph_d   = (blk_en && start_det) ? PH_ADDR : PH_IDLE;
      cnt_d  = '0;  ack_d = 1'b0;  tx_d = 1'b0;  arm_d = 1'b0;
      take_d = 1'b0;  busy_d = 1'b0;  hit_d = 1'b0;  nack_d = 1'b0;
    end else begin
      if (arm_req) arm_d = 1'b1;
      if (in_xfer) begin
        if (!ack_q) begin
          if (scl_rise) begin
            if (cnt_q == '0) begin
              take_d = (ph_q == PH_ADDR) | arm_q;
              busy_d = take_d;
            end
            if (take_d && !((ph_q == PH_DATA) && tx_q)) shift_in = 1'b1;
            if (cnt_q != CNT_LAST) cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              cnt_d = '0;
              if (ph_q == PH_ADDR) begin
                if (fmt_free || addr_eq) begin
                  ack_d = 1'b1;
                  hit_d = 1'b1;
                  tx_d  = ~fmt_free & dat_q[0];
                end else begin
                  ph_d   = PH_SKIP;
                  busy_d = 1'b0;
                  take_d = 1'b0;
                end
              end else begin
                ack_d = 1'b1;
              end
            end else if ((cnt_q != '0) && (ph_q == PH_DATA) && tx_q && take_q) begin
              shift_out = 1'b1;
            end
          end
        end else begin
          if (scl_rise) begin
            if ((ph_q == PH_DATA) && tx_q && take_q) nack_d = sda_now;
          end else if (scl_fall) begin
            ack_d  = 1'b0;
            busy_d = 1'b0;
            done_d = take_q;
            if ((ph_q == PH_DATA) && take_q) arm_d = 1'b0;
            take_d = 1'b0;
            nack_d = 1'b0;
            ph_d   = nack_q ? PH_SKIP : PH_DATA;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  cnt_q <= '0;  ack_q <= 1'b0;  tx_q <= 1'b0;
      arm_q <= 1'b0;  take_q <= 1'b0;  busy_q <= 1'b0;  hit_q <= 1'b0;
      nack_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;  cnt_q <= cnt_d;  ack_q <= ack_d;  tx_q <= tx_d;
      arm_q <= arm_d;  take_q <= take_d;  busy_q <= busy_d;  hit_q <= hit_d;
      nack_q <= nack_d;  done_q <= done_d;
    end
  end

  logic ack_drive, tx_drive;
  assign ack_drive = ack_q & ((ph_q == PH_ADDR) | ((ph_q == PH_DATA) & ~tx_q & take_q));
  assign tx_drive  = (ph_q == PH_DATA) & tx_q & ~ack_q &
                     ((cnt_q == '0) ? arm_q : take_q) & ~dat_q[DW-1];

  assign sda_pull   = ack_drive | tx_drive;
  assign shift_busy = busy_q | busy_d;
  assign busy       = busy_q;
  assign byte_done  = done_q;
  assign addressed  = hit_q;
  assign tx_mode    = tx_q;
endmodule

// File: rtl/i2c_tgt_shifter.sv
module i2c_tgt_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_en,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic          cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          busy,
  output logic          byte_done,
  output logic          acc_err,
  output logic          addressed,
  output logic          tx_mode
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  logic shift_in, shift_out, shift_busy, arm_req;
  logic [DW-1:0] dat_w, own_w;

  i2cts_bus_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cts_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .blk_en(blk_en),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .shift_busy(shift_busy), .shift_in(shift_in), .shift_out(shift_out),
    .sda_now(sda_in), .dat_q(dat_w), .own_q(own_w), .cpu_rdata(cpu_rdata),
    .arm_req(arm_req), .acc_err(acc_err)
  );

  i2cts_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .blk_en(blk_en),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_now(sda_in), .arm_req(arm_req), .dat_q(dat_w), .own_q(own_w),
    .shift_in(shift_in), .shift_out(shift_out), .shift_busy(shift_busy),
    .busy(busy), .byte_done(byte_done), .addressed(addressed),
    .tx_mode(tx_mode), .sda_pull(sda_pull)
  );
endmodule

// File: rtl/i2cts_chk.sv
module i2cts_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_en,
  input logic          cpu_sel,
  input logic          cpu_addr,
  input logic [DW-1:0] cpu_rdata,
  input logic [DW-1:0] own_q,
  input logic          busy,
  input logic          byte_done,
  input logic          acc_err,
  input logic          sda_pull,
  input logic          addressed
);
  AST_OWN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_en |=> $stable(own_q)); // R10
  AST_OWN_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && cpu_addr) |-> (cpu_rdata == '0)); // R10
  AST_ERR_ON_BUSY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_addr && busy) |=> acc_err); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !busy); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_en && !$past(blk_en)) |-> (!sda_pull && !busy && !addressed)); // R13
endmodule

bind i2c_tgt_shifter i2cts_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .blk_en(blk_en), .cpu_sel(cpu_sel),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .own_q(own_w), .busy(busy),
  .byte_done(byte_done), .acc_err(acc_err), .sda_pull(sda_pull), .addressed(addressed)
);

// File: tb/i2c_tgt_shifter_bench.sv
module i2c_tgt_shifter_bench;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, blk_en, scl_m, sda_m, cpu_sel, cpu_wr, cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       sda_pull, busy, byte_done, acc_err, addressed, tx_mode;
  logic       sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_tgt_shifter u_i2c_tgt_shifter (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy), .byte_done(byte_done),
    .acc_err(acc_err), .addressed(addressed), .tx_mode(tx_mode)
  );

  int   checks = 0, errors = 0, done_seen = 0, err_seen = 0;
  logic busy_mid;
  bit   finished = 1'b0;

  always @(negedge clk) begin
    if (byte_done) done_seen++;
    if (acc_err) err_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] v);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = v;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic a, output logic [7:0] v);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    #1 v = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic set_own(input logic [7:0] v);
    blk_en = 1'b0; wclk(2);
    cpu_write(1'b1, v);
    blk_en = 1'b1; wclk(2);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send_bit(input logic b, input bit grab, output logic r);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    r = sda_bus;
    if (grab) busy_mid = busy;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] wb, input logic mack, input int poke,
                           output logic [7:0] rb, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      send_bit(wb[i], i == 4, r);
      rb[i] = r;
      if (i == poke) cpu_write(1'b0, 8'h3C);
    end
    send_bit(mack, 1'b0, ack);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb, rd;
    logic       ack, r;
    int         d0, e0;
    logic [7:0] rx_pats[6];
    logic [7:0] tx_pats[4];
    rx_pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    tx_pats = '{8'h96, 8'h00, 8'hFF, 8'h5B};
    rst_n = 1'b0; blk_en = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = 1'b0; cpu_wdata = 8'h00;
    wclk(5); rst_n = 1'b1; wclk(6);

    // R1 reset state
    cpu_read(1'b1, rd);
    chk(rd == 8'h00, "R1 address reg reset", rd, 0);
    chk(!sda_pull && !busy && !addressed && !byte_done, "R1 outputs idle",
        {sda_pull, busy, addressed, byte_done}, 0);

    // R10 address register lock
    cpu_write(1'b1, 8'h54); cpu_read(1'b1, rd);
    chk(rd == 8'h54, "R10 write while disabled", rd, 8'h54);
    blk_en = 1'b1; wclk(1);
    cpu_read(1'b1, rd);
    chk(rd == 8'h00, "R10 read masked while enabled", rd, 0);
    cpu_write(1'b1, 8'h12);
    blk_en = 1'b0; wclk(1);
    cpu_read(1'b1, rd);
    chk(rd == 8'h54, "R10 write ignored while enabled", rd, 8'h54);

    // R3 R4 sweep of all own addresses
    for (int a = 0; a < 128; a++) begin
      logic [7:0] own_v, hit_b, miss_b;
      own_v  = {a[6:0], 1'b0};
      hit_b  = {a[6:0], a[0]};
      miss_b = {a[6:0] ^ (7'd1 << (a % 7)), 1'b0};
      set_own(own_v);
      bus_start();
      d0 = done_seen;
      send_byte(hit_b, 1'b1, -1, rb, ack);
      chk(ack == 1'b0, "R3 ack on address match", ack, 0);
      chk(addressed == 1'b1, "R3 addressed set", addressed, 1);
      chk(done_seen == d0 + 1, "R8 done after address byte", done_seen - d0, 1);
      bus_stop();
      chk(addressed == 1'b0, "R2 stop clears addressed", addressed, 0);
      bus_start();
      d0 = done_seen;
      send_byte(miss_b, 1'b1, -1, rb, ack);
      chk(ack == 1'b1, "R4 no ack on mismatch", ack, 1);
      send_byte(own_v, 1'b1, -1, rb, ack);
      chk(ack == 1'b1, "R4 ignored until next start", ack, 1);
      chk(done_seen == d0, "R4 no done while ignoring", done_seen - d0, 0);
      bus_stop();
    end

    // R6 receive path, R8 busy window
    set_own(8'hA4);
    bus_start();
    chk(busy == 1'b0, "R8 not busy before first bit", busy, 0);
    send_byte(8'hA4, 1'b1, -1, rb, ack);
    chk(ack == 1'b0, "R6 address ack", ack, 0);
    chk(busy_mid == 1'b1, "R8 busy mid byte", busy_mid, 1);
    chk(busy == 1'b0, "R8 busy cleared after ack clock", busy, 0);
    chk(tx_mode == 1'b0, "R6 receive direction", tx_mode, 0);
    cpu_read(1'b0, rd);
    chk(rd == 8'hA4, "R6 address byte held", rd, 8'hA4);
    foreach (rx_pats[k]) begin
      send_byte(rx_pats[k], 1'b1, -1, rb, ack);
      chk(ack == 1'b0, "R6 data byte acked", ack, 0);
      cpu_read(1'b0, rd);
      chk(rd == rx_pats[k], "R6 data MSB first", rd, rx_pats[k]);
    end
    // R9 write in the middle of a byte
    e0 = err_seen;
    send_byte(8'hC3, 1'b1, 4, rb, ack);
    chk(err_seen == e0 + 1, "R9 access error pulse", err_seen - e0, 1);
    chk(ack == 1'b0, "R9 byte still acked", ack, 0);
    cpu_read(1'b0, rd);
    chk(rd == 8'hC3, "R9 busy write discarded", rd, 8'hC3);
    // R7 unarmed receive byte
    send_byte(8'h66, 1'b1, -1, rb, ack);
    d0 = done_seen;
    send_byte(8'h99, 1'b1, -1, rb, ack);
    chk(ack == 1'b1, "R7 unarmed byte not acked", ack, 1);
    chk(done_seen == d0, "R7 no done for unarmed byte", done_seen - d0, 0);
    cpu_read(1'b0, rd);
    chk(rd == 8'h66, "R7 data register untouched", rd, 8'h66);
    bus_stop();

    // R5 transmit path
    bus_start();
    send_byte(8'hA5, 1'b1, -1, rb, ack);
    chk(ack == 1'b0, "R5 address ack", ack, 0);
    chk(tx_mode == 1'b1, "R5 transmit direction", tx_mode, 1);
    d0 = done_seen;
    send_byte(8'hFF, 1'b0, -1, rb, ack);
    chk(rb == 8'hFF, "R7 unarmed transmit released", rb, 8'hFF);
    chk(done_seen == d0, "R7 no done unarmed transmit", done_seen - d0, 0);
    foreach (tx_pats[k]) begin
      cpu_write(1'b0, tx_pats[k]);
      send_byte(8'hFF, 1'b0, -1, rb, ack);
      chk(rb == tx_pats[k], "R5 transmit MSB first", rb, tx_pats[k]);
      chk(ack == 1'b0, "R5 SDA released in ack clock", ack, 0);
    end
    // R12 master NACK ends transmit
    cpu_write(1'b0, 8'h3E);
    send_byte(8'hFF, 1'b1, -1, rb, ack);
    chk(rb == 8'h3E, "R12 last byte before nack", rb, 8'h3E);
    cpu_write(1'b0, 8'h00);
    send_byte(8'hFF, 1'b0, -1, rb, ack);
    chk(rb == 8'hFF, "R12 released after nack", rb, 8'hFF);
    bus_stop();

    // R2 repeated start in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, r);
    bus_start();
    send_byte(8'hA4, 1'b1, -1, rb, ack);
    chk(ack == 1'b0, "R2 restart re-arms compare", ack, 0);
    bus_stop();

    // R11 address-free format
    set_own(8'h31);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] v;
      v = 8'h9E ^ (8'h47 * k[7:0]);
      bus_start();
      send_byte(v, 1'b1, -1, rb, ack);
      chk(ack == 1'b0, "R11 ack without compare", ack, 0);
      chk(tx_mode == 1'b0, "R11 receive only", tx_mode, 0);
      cpu_read(1'b0, rd);
      chk(rd == v, "R11 first byte is data", rd, v);
      bus_stop();
    end

    // R13 disabled block ignores bus
    blk_en = 1'b0; wclk(2);
    cpu_write(1'b1, 8'hA4);
    bus_start();
    d0 = done_seen;
    send_byte(8'hA4, 1'b1, -1, rb, ack);
    chk(ack == 1'b1, "R13 no ack while disabled", ack, 1);
    chk(done_seen == d0 && !addressed, "R13 no activity while disabled",
        done_seen - d0 + addressed, 0);
    bus_stop();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule